// File: doc/BRIEF.md
# Immediate-Displacement Execute Unit

This unit carries out three instructions of a 64-bit load/store core that share one encoding shape: a base register field, a target/source register field and a 16-bit signed displacement. The three are add-immediate, load word with zero extension and store word. The unit holds its own 32 x 64-bit register file with two read ports and one write port. It forms a base value and a sum. For add-immediate the sum goes straight back to the register file. For a memory operation the sum becomes the effective address of a 4-byte access on a simple request/ready memory port.

A sequencer issues one instruction at a time while the unit is idle. The unit reports completion with a single-cycle pulse. Every register write leaves the unit on a writeback port (valid, index, data) at the edge where it commits, so that the pipeline around the unit can follow results.

Top module: `dfx_exec`

## Requirements
- R1: After synchronous reset the unit is idle (issue_ready high, done, mem_req_valid and wb_valid low) and every register reads as zero.
- R2: When the base field is 0, the base value is the constant zero, not the contents of register 0.
- R3: The sum is the base value plus the 16-bit displacement sign-extended to 64 bits, taken modulo 2^64, with no carry or overflow indication.
- R4: Opcode 2'b00 (add-immediate) writes the sum into the register named by the target field, with no memory request.
- R5: Opcode 2'b01 (load word) requests 4 bytes at the sum with mem_we low. When ready is sampled, it writes the target register with 32 zero bits above the returned word. Byte order is big-endian: the byte at the lowest address sits on mem_rdata[31:24].
- R6: Opcode 2'b10 (store word) requests a write (mem_we high) at the sum of the low 32 bits of the register named by the target field, with the byte for the lowest address on mem_wdata[31:24]. It makes no register write.
- R7: A memory request holds mem_req_valid, mem_addr, mem_we and mem_wdata unchanged until mem_req_ready is sampled high.
- R8: A load's register write happens only in the cycle where mem_req_ready is sampled high. A store never raises wb_valid.
- R9: An instruction is accepted only while issue_ready is high. issue_valid during a busy cycle is ignored. Each accepted instruction yields exactly one done pulse, one cycle long.
- R10: Register 0 is an ordinary register as target or store source. Only the base field treats 0 specially.
- R11: Opcode 2'b11 completes with a done pulse and neither writes a register nor requests memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Unit idle; an offered instruction is taken this cycle |
| issue_op | input | 2 | 00 add-immediate, 01 load word, 10 store word, 11 no operation |
| issue_ra | input | 5 | Base register field (0 = constant zero) |
| issue_rt | input | 5 | Target register (load/add) or source register (store) |
| issue_imm | input | 16 | Signed displacement |
| done | output | 1 | One-cycle completion pulse |
| mem_req_valid | output | 1 | Memory request active |
| mem_req_ready | input | 1 | Memory accepts request / returns read data |
| mem_addr | output | 64 | Effective address |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wdata | output | 32 | Store word, big-endian byte lanes |
| mem_rdata | input | 32 | Load word, big-endian byte lanes |
| wb_valid | output | 1 | Register write commits at this edge |
| wb_reg | output | 5 | Register being written |
| wb_data | output | 64 | Value being written |

## Verification
A corrupted register value shows up later, not at once. It appears when a later instruction uses that register as a base (wrong mem_addr) or as a store source (wrong mem_wdata). The bench therefore chains dependent instructions and stores every register it touches. A sequencer that slips a state shows within a cycle or two: a missing or doubled done, a writeback before ready, or a request field that changes while ready is low. A busy unit that wrongly takes a stray instruction produces an unexpected writeback on the next cycle.

// File: rtl/dfx_pkg.sv
package dfx_pkg;

    localparam int XLEN_D  = 64;
    localparam int WORDW_D = 32;
    localparam int NREGS_D = 32;
    localparam int IMMW_D  = 16;
    localparam int RIDX_D  = $clog2(NREGS_D);

    typedef enum logic [1:0] {
        OP_ADDI = 2'b00,
        OP_LDW  = 2'b01,
        OP_STW  = 2'b10,
        OP_NOP  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_EXEC = 2'b01,
        ST_MEM  = 2'b10
    } state_e;

    typedef struct packed {
        op_e                op;
        logic [RIDX_D-1:0]  ra;
        logic [RIDX_D-1:0]  rt;
        logic [IMMW_D-1:0]  imm;
    } instr_t;

    function automatic logic [XLEN_D-1:0] sext_disp(input logic [IMMW_D-1:0] d);
        return {{(XLEN_D-IMMW_D){d[IMMW_D-1]}}, d};
    endfunction

    function automatic logic is_mem_op(input op_e op);
        return (op == OP_LDW) || (op == OP_STW);
    endfunction

endpackage

// File: rtl/dfx_regfile.sv
module dfx_regfile #(
    parameter int NREGS = 32,
    parameter int XLEN  = 64,
    parameter int B_W   = 32,
    localparam int RIDX = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [RIDX-1:0] rd_a_idx,
    output logic [XLEN-1:0] rd_a_data,
    input  logic [RIDX-1:0] rd_b_idx,
    output logic [B_W-1:0]  rd_b_data,
    input  logic            wr_en,
    input  logic [RIDX-1:0] wr_idx,
    input  logic [XLEN-1:0] wr_data
);

    logic [XLEN-1:0] regs_q [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= '0;
            end
        end else if (wr_en) begin
            regs_q[wr_idx] <= wr_data;
        end
    end

    logic [XLEN-1:0] b_full;

    always_comb begin
        rd_a_data = regs_q[rd_a_idx];
        b_full    = regs_q[rd_b_idx];
        rd_b_data = b_full[B_W-1:0];
    end

    if (B_W < XLEN) begin : g_b_narrow
        logic unused_b_hi;
        assign unused_b_hi = ^b_full[XLEN-1:B_W];
    end

endmodule

// File: rtl/dfx_agen.sv
module dfx_agen
    import dfx_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMMW  = 16,
    parameter int RIDX  = 5
) (
    input  logic [RIDX-1:0] ra_idx,
    input  logic [XLEN-1:0] ra_value,
    input  logic [IMMW-1:0] disp,
    output logic [XLEN-1:0] sum
);

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] disp_x;

    always_comb begin
        base   = (ra_idx == '0) ? '0 : ra_value;
        disp_x = {{(XLEN-IMMW){disp[IMMW-1]}}, disp};
        sum    = base + disp_x;
    end

endmodule

// File: rtl/dfx_ctrl.sv
module dfx_ctrl
    import dfx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   issue_valid,
    input  logic   mem_op,
    input  logic   mem_req_ready,
    output state_e st,
    output logic   accept,
    output logic   done
);

    state_e st_q, st_d;
    logic   done_d;

    always_comb begin
        st_d   = st_q;
        done_d = 1'b0;
        accept = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (issue_valid) begin
                    accept = 1'b1;
                    st_d   = ST_EXEC;
                end
            end
            ST_EXEC: begin
                if (mem_op) begin
                    st_d = ST_MEM;
                end else begin
                    st_d   = ST_IDLE;
                    done_d = 1'b1;
                end
            end
            ST_MEM: begin
                if (mem_req_ready) begin
                    st_d   = ST_IDLE;
                    done_d = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            done <= 1'b0;
        end else begin
            st_q <= st_d;
            done <= done_d;
        end
    end

    assign st = st_q;

endmodule

// File: rtl/dfx_exec.sv
module dfx_exec
    import dfx_pkg::*;
#(
    parameter int XLEN  = XLEN_D,
    parameter int WORDW = WORDW_D,
    parameter int NREGS = NREGS_D,
    parameter int IMMW  = IMMW_D,
    localparam int RIDX = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_valid,
    output logic             issue_ready,
    input  logic [1:0]       issue_op,
    input  logic [RIDX-1:0]  issue_ra,
    input  logic [RIDX-1:0]  issue_rt,
    input  logic [IMMW-1:0]  issue_imm,
    output logic             done,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [XLEN-1:0]  mem_addr,
    output logic             mem_we,
    output logic [WORDW-1:0] mem_wdata,
    input  logic [WORDW-1:0] mem_rdata,
    output logic             wb_valid,
    output logic [RIDX-1:0]  wb_reg,
    output logic [XLEN-1:0]  wb_data
);

    op_e              op_q;
    logic [RIDX-1:0]  ra_q;
    logic [RIDX-1:0]  rt_q;
    logic [IMMW-1:0]  imm_q;
    logic [XLEN-1:0]  addr_q;
    logic [WORDW-1:0] wdata_q;

    state_e           st;
    logic             accept;
    logic [XLEN-1:0]  ra_value;
    logic [WORDW-1:0] rs_word;
    logic [XLEN-1:0]  sum;

    dfx_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .issue_valid   (issue_valid),
        .mem_op        (is_mem_op(op_q)),
        .mem_req_ready (mem_req_ready),
        .st            (st),
        .accept        (accept),
        .done          (done)
    );

    dfx_regfile #(
        .NREGS (NREGS),
        .XLEN  (XLEN),
        .B_W   (WORDW)
    ) u_rf (
        .clk       (clk),
        .rst       (rst),
        .rd_a_idx  (ra_q),
        .rd_a_data (ra_value),
        .rd_b_idx  (rt_q),
        .rd_b_data (rs_word),
        .wr_en     (wb_valid),
        .wr_idx    (wb_reg),
        .wr_data   (wb_data)
    );

    dfx_agen #(
        .XLEN (XLEN),
        .IMMW (IMMW),
        .RIDX (RIDX)
    ) u_agen (
        .ra_idx   (ra_q),
        .ra_value (ra_value),
        .disp     (imm_q),
        .sum      (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= OP_NOP;
            ra_q    <= '0;
            rt_q    <= '0;
            imm_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            if (accept) begin
                op_q  <= op_e'(issue_op);
                ra_q  <= issue_ra;
                rt_q  <= issue_rt;
                imm_q <= issue_imm;
            end
            if (st == ST_EXEC && is_mem_op(op_q)) begin
                addr_q  <= sum;
                wdata_q <= rs_word;
            end
        end
    end

    logic wb_from_alu;
    logic wb_from_mem;

    always_comb begin
        issue_ready   = (st == ST_IDLE);
        mem_req_valid = (st == ST_MEM);
        mem_we        = mem_req_valid && (op_q == OP_STW);
        mem_addr      = addr_q;
        mem_wdata     = wdata_q;
        wb_from_alu   = (st == ST_EXEC) && (op_q == OP_ADDI);
        wb_from_mem   = mem_req_valid && mem_req_ready && (op_q == OP_LDW);
        wb_valid      = wb_from_alu || wb_from_mem;
        wb_reg        = rt_q;
        wb_data       = wb_from_mem ? {{(XLEN-WORDW){1'b0}}, mem_rdata} : sum;
    end

endmodule

// File: rtl/dfx_exec_chk.sv
module dfx_exec_chk #(
    parameter int XLEN  = 64,
    parameter int WORDW = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             issue_ready,
    input logic             done,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [XLEN-1:0]  mem_addr,
    input logic             mem_we,
    input logic [WORDW-1:0] mem_wdata,
    input logic [WORDW-1:0] mem_rdata,
    input logic             wb_valid,
    input logic [XLEN-1:0]  wb_data
);

    a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    a_r8_store_no_wb: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_we) |-> !wb_valid);

    a_r8_load_waits_ready: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |-> !wb_valid);

    a_r5_zero_upper: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && mem_req_valid) |->
            (wb_data == {{(XLEN-WORDW){1'b0}}, mem_rdata}));

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_busy_during_req: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !issue_ready);

    a_r9_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> issue_ready);

endmodule

bind dfx_exec dfx_exec_chk #(
    .XLEN  (XLEN),
    .WORDW (WORDW)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .issue_ready   (issue_ready),
    .done          (done),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_addr      (mem_addr),
    .mem_we        (mem_we),
    .mem_wdata     (mem_wdata),
    .mem_rdata     (mem_rdata),
    .wb_valid      (wb_valid),
    .wb_data       (wb_data)
);

// File: tb/dfx_exec_tb_top.sv
`timescale 1ns/1ps
module dfx_exec_tb_top;

    localparam int XLEN  = 64;
    localparam int WORDW = 32;
    localparam int RIDX  = 5;
    localparam int IMMW  = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             issue_valid = 1'b0;
    logic             issue_ready;
    logic [1:0]       issue_op = '0;
    logic [RIDX-1:0]  issue_ra = '0;
    logic [RIDX-1:0]  issue_rt = '0;
    logic [IMMW-1:0]  issue_imm = '0;
    logic             done;
    logic             mem_req_valid;
    logic             mem_req_ready = 1'b0;
    logic [XLEN-1:0]  mem_addr;
    logic             mem_we;
    logic [WORDW-1:0] mem_wdata;
    logic [WORDW-1:0] mem_rdata = '0;
    logic             wb_valid;
    logic [RIDX-1:0]  wb_reg;
    logic [XLEN-1:0]  wb_data;

    always #2 clk = ~clk;

    dfx_exec dut_i (
        .clk(clk), .rst(rst),
        .issue_valid(issue_valid), .issue_ready(issue_ready),
        .issue_op(issue_op), .issue_ra(issue_ra), .issue_rt(issue_rt), .issue_imm(issue_imm),
        .done(done),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data)
    );

    typedef struct { logic [RIDX-1:0] idx; logic [XLEN-1:0] data; string tag; } wb_item_t;
    typedef struct { logic [XLEN-1:0] addr; logic we; logic [WORDW-1:0] wdata; string tag; } mem_item_t;

    wb_item_t  wb_q[$];
    mem_item_t mem_q[$];

    int n_vec = 0;
    int n_bad = 0;
    int issued = 0;
    int done_seen = 0;
    bit finished = 1'b0;

    logic [XLEN-1:0] shadow [32];
    bit [7:0] mem_m [logic [XLEN-1:0]];

    task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit [7:0] rd_byte(input logic [XLEN-1:0] a);
        if (mem_m.exists(a)) return mem_m[a];
        return a[7:0] ^ 8'h5A;
    endfunction

    function automatic logic [WORDW-1:0] rd_word(input logic [XLEN-1:0] a);
        return {rd_byte(a), rd_byte(a + 1), rd_byte(a + 2), rd_byte(a + 3)};
    endfunction

    // driver: computes expectations from the requirements, then issues
    task automatic run(input logic [1:0] op, input logic [4:0] ra, input logic [4:0] rt,
                       input logic [15:0] imm, input bit junk, input string tag);
        logic [XLEN-1:0] base, ea;
        base = (ra == 0) ? '0 : shadow[ra];
        ea   = base + {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
        case (op)
            2'b00: begin
                wb_q.push_back('{rt, ea, tag});
                shadow[rt] = ea;
            end
            2'b01: begin
                mem_q.push_back('{ea, 1'b0, '0, tag});
                wb_q.push_back('{rt, {32'h0, rd_word(ea)}, tag});
                shadow[rt] = {32'h0, rd_word(ea)};
            end
            2'b10: mem_q.push_back('{ea, 1'b1, shadow[rt][31:0], tag});
            default: ;
        endcase
        @(negedge clk);
        issue_valid = 1'b1; issue_op = op; issue_ra = ra; issue_rt = rt; issue_imm = imm;
        issued++;
        #1 chk({tag, " R9 ready at issue"}, issue_ready, 1);
        @(negedge clk);
        issue_valid = 1'b0;
        if (junk) begin
            issue_valid = 1'b1; issue_op = 2'b00; issue_ra = 5'd0; issue_rt = 5'd11; issue_imm = 16'h1234;
            @(negedge clk);
            issue_valid = 1'b0;
        end
        while (done_seen != issued) @(negedge clk);
    endtask

    // memory responder
    initial begin
        logic [3:0] lfsr = 4'h9;
        int wait_n = 0;
        forever begin
            @(negedge clk);
            if (mem_req_ready) begin
                mem_req_ready = 1'b0;
            end else if (mem_req_valid) begin
                if (wait_n == 0) begin
                    mem_req_ready = 1'b1;
                    mem_rdata = rd_word(mem_addr);
                end else begin
                    wait_n--;
                end
            end else begin
                lfsr   = {lfsr[2:0], lfsr[3] ^ lfsr[2]};
                wait_n = int'(lfsr[1:0]);
            end
        end
    end

    // monitor / scoreboard
    initial begin
        bit pend = 1'b0;
        logic [XLEN-1:0] p_addr;
        logic p_we;
        logic [WORDW-1:0] p_wdata;
        forever begin
            @(negedge clk);
            #1;
            if (!rst) begin
                if (done) done_seen++;
                if (pend) begin
                    chk("R7 valid held", mem_req_valid, 1);
                    chk("R7 addr held", mem_addr, p_addr);
                    chk("R7 we held", mem_we, p_we);
                    chk("R7 wdata held", mem_wdata, p_wdata);
                end
                pend = mem_req_valid && !mem_req_ready;
                p_addr = mem_addr; p_we = mem_we; p_wdata = mem_wdata;
                if (mem_req_valid && mem_req_ready) begin
                    if (mem_q.size() == 0) begin
                        chk("R8 unexpected mem request", 1, 0);
                    end else begin
                        mem_item_t m;
                        m = mem_q.pop_front();
                        chk({m.tag, " addr"}, mem_addr, m.addr);
                        chk({m.tag, " we"}, mem_we, m.we);
                        if (m.we) begin
                            chk({m.tag, " wdata"}, mem_wdata, m.wdata);
                            mem_m[mem_addr]     = mem_wdata[31:24];
                            mem_m[mem_addr + 1] = mem_wdata[23:16];
                            mem_m[mem_addr + 2] = mem_wdata[15:8];
                            mem_m[mem_addr + 3] = mem_wdata[7:0];
                        end
                    end
                end
                if (wb_valid) begin
                    if (wb_q.size() == 0) begin
                        chk("R8/R9 unexpected writeback", 1, 0);
                    end else begin
                        wb_item_t w;
                        w = wb_q.pop_front();
                        chk({w.tag, " wb reg"}, wb_reg, w.idx);
                        chk({w.tag, " wb data"}, wb_data, w.data);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=complete");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 issue_ready after reset", issue_ready, 1);
        chk("R1 done after reset", done, 0);
        chk("R1 mem_req_valid after reset", mem_req_valid, 0);
        chk("R1 wb_valid after reset", wb_valid, 0);

        run(2'b10, 5'd0, 5'd7,  16'h0010, 0, "R1 reg zero store");
        run(2'b00, 5'd0, 5'd1,  16'h7FFF, 0, "R2 R4 addi base zero");
        run(2'b00, 5'd0, 5'd2,  16'h8000, 0, "R2 R4 addi negative");
        run(2'b00, 5'd1, 5'd3,  16'hFFFF, 1, "R3 R4 R9 addi reg plus minus one, busy issue ignored");
        run(2'b00, 5'd2, 5'd4,  16'h8000, 0, "R3 addi wrap");
        run(2'b10, 5'd1, 5'd2,  16'h0004, 1, "R6 R9 store low word");
        run(2'b01, 5'd1, 5'd5,  16'h0004, 0, "R5 load back stored word");
        run(2'b01, 5'd0, 5'd6,  16'h0100, 0, "R5 load big-endian pattern");
        run(2'b01, 5'd3, 5'd9,  16'hFFFE, 0, "R3 R5 load negative disp");
        run(2'b01, 5'd2, 5'd10, 16'h8000, 0, "R3 R5 load wrapped address");
        run(2'b00, 5'd0, 5'd0,  16'h0005, 0, "R10 write reg0");
        run(2'b00, 5'd0, 5'd8,  16'h0003, 0, "R2 R10 base field zero ignores reg0");
        run(2'b10, 5'd0, 5'd0,  16'h0200, 0, "R10 store from reg0");
        run(2'b11, 5'd1, 5'd12, 16'h0040, 0, "R11 no-op");
        run(2'b10, 5'd0, 5'd12, 16'h0300, 0, "R11 target untouched");
        run(2'b10, 5'd0, 5'd11, 16'h0304, 0, "R9 busy issue left reg11 untouched");
        run(2'b10, 5'd0, 5'd4,  16'hFFF0, 0, "R6 store wrap value");
        run(2'b01, 5'd0, 5'd13, 16'hFFF0, 0, "R5 R6 load stored bytes");
        run(2'b10, 5'd0, 5'd13, 16'h0400, 0, "R5 loaded upper zero");

        repeat (4) @(negedge clk);
        chk("R9 done pulses per instruction", done_seen, issued);
        chk("R8 expected writebacks consumed", wb_q.size(), 0);
        chk("R6 expected requests consumed", mem_q.size(), 0);
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule